// File: doc/BRIEF.md
# Ethernet PHY Management Register File

This block holds the management registers of a 10/100 Ethernet PHY and serves them through a plain host register interface. The host first loads a 32-bit target word that carries two 8-bit fields: a PHY address and a register number. It then either pulses a write strobe with 16-bit write data, or pulses a read strobe and collects 16-bit read data one clock later. Any access whose PHY address differs from the configured address is treated as aimed at another device on the shared bus.

The register file holds the control and advertisement registers, which are writable, and status and link-partner registers, which are derived from a link-up input. Two identifier registers return fixed parameter values. Setting the reset bit in a control write puts the writable registers back to their defaults. All other register numbers read as zero and ignore writes. The serial management wire protocol and the analog PHY are outside this block.

Top module: `mii_mgmt_regs`

## Requirements
- R1: After reset, control (register 0) reads 0x3100 (bit 13 speed 100, bit 12 auto-negotiation enable, bit 8 full duplex), advertisement (register 4) reads 0x01E1, and rd_data is 0.
- R2: Status (register 1) reads 0x7848 while the link is down (bits 14, 13, 12, 11 for the four speed/duplex abilities, bit 6 preamble suppression, bit 3 auto-negotiation ability) and 0x786C while it is up (adding bit 5 negotiation complete and bit 2 link status).
- R3: Link partner (register 5) reads 0x0080 while the link is down and 0x01E1 while it is up.
- R4: A change on link_up is visible in a read strobed on the clock edge after the edge that samples it.
- R5: A read with a PHY address field (target bits [15:8]) not equal to PHY_ADDR returns 0xFFFF.
- R6: A write with a PHY address field not equal to PHY_ADDR changes no register.
- R7: A write to control without bit 15 stores the 16-bit value unchanged; a write to advertisement stores its value unchanged.
- R8: A control write with bit 15 set restores control to 0x3100 and advertisement to 0x01E1.
- R9: Writes to status, both identifiers, link partner and every register number other than 0 and 4 change no register.
- R10: Registers 2 and 3 read the parameters ID_HI and ID_LO.
- R11: Every register number of 6 and above (target bits [7:0]) reads 0.
- R12: rd_data updates on the clock edge where rd_en is high and holds its value on every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Link state from the PHY |
| tgt_we | input | 1 | Load the target word |
| tgt_wdata | input | 32 | Target word: PHY address and register number fields |
| wr_en | input | 1 | Write strobe for the targeted register |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe for the targeted register |
| rd_data | output | 16 | Registered read data |

## Verification
Reads are swept over register numbers 0 to 63 with the link both down and up, which separates the link-dependent status and partner values from the fixed identifiers and the zero-reading space. A sweep of all 256 PHY addresses on a control read tells the matching address apart from every other, and a write with a foreign address followed by a matched read shows it left no trace. Writes of all-ones to every non-writable register number, then a full readback, distinguish the two writable registers from the rest, and a control write with the reset bit tells a soft reset from a stored value.

// File: rtl/mii_mgmt_regs.sv
module mii_mgmt_regs #(
  parameter logic [7:0]  PHY_ADDR   = 8'd1,
  parameter logic [15:0] ID_HI      = 16'h0243,
  parameter logic [15:0] ID_LO      = 16'h0C54,
  parameter int          TGT_W      = 32,
  parameter int          ADDR_SHIFT = 8,
  parameter int          REG_SHIFT  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_up,
  input  logic             tgt_we,
  input  logic [TGT_W-1:0] tgt_wdata,
  input  logic             wr_en,
  input  logic [15:0]      wr_data,
  input  logic             rd_en,
  output logic [15:0]      rd_data
);
  localparam logic [15:0] CTRL_DEF = 16'h3100;
  localparam logic [15:0] ADV_DEF  = 16'h01E1;
  localparam logic [15:0] STS_BASE = 16'h7848;
  localparam logic [15:0] STS_LINK = 16'h0024;
  localparam logic [15:0] LP_DOWN  = 16'h0080;
  localparam logic [15:0] LP_UP    = 16'h01E1;
  localparam logic [7:0]  N_CTRL = 8'd0, N_STS = 8'd1, N_IDH = 8'd2,
                          N_IDL  = 8'd3, N_ADV = 8'd4, N_LP  = 8'd5;

  logic [TGT_W-1:0] tgt_q;
  logic [15:0]      ctrl_q, adv_q, rd_next;
  logic             link_q;

  wire [7:0] sel_addr = tgt_q[ADDR_SHIFT +: 8];
  wire [7:0] sel_reg  = tgt_q[REG_SHIFT +: 8];
  wire       hit      = (sel_addr == PHY_ADDR);
  wire       wr_hit   = wr_en && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_q  <= '0;
      link_q <= 1'b0;
    end else begin
      link_q <= link_up;
      if (tgt_we) tgt_q <= tgt_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_DEF;
      adv_q  <= ADV_DEF;
    end else if (wr_hit && sel_reg == N_CTRL) begin
      if (wr_data[15]) begin
        ctrl_q <= CTRL_DEF;
        adv_q  <= ADV_DEF;
      end else begin
        ctrl_q <= wr_data;
      end
    end else if (wr_hit && sel_reg == N_ADV) begin
      adv_q <= wr_data;
    end
  end

  always_comb begin
    if (!hit) rd_next = 16'hFFFF;
    else begin
      case (sel_reg)
        N_CTRL:  rd_next = ctrl_q;
        N_STS:   rd_next = link_q ? (STS_BASE | STS_LINK) : STS_BASE;
        N_IDH:   rd_next = ID_HI;
        N_IDL:   rd_next = ID_LO;
        N_ADV:   rd_next = adv_q;
        N_LP:    rd_next = link_q ? LP_UP : LP_DOWN;
        default: rd_next = 16'h0000;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= 16'h0000;
    else if (rd_en) rd_data <= rd_next;
  end

  assert_foreign_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !tgt_we && tgt_q[ADDR_SHIFT +: 8] != PHY_ADDR) |=> rd_data == 16'hFFFF);

  assert_foreign_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tgt_q[ADDR_SHIFT +: 8] != PHY_ADDR) |=> ($stable(ctrl_q) && $stable(adv_q)));

  assert_soft_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && sel_reg == N_CTRL && wr_data[15]) |=> (ctrl_q == CTRL_DEF && adv_q == ADV_DEF));

  assert_readonly_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_reg != N_CTRL && sel_reg != N_ADV) |=> ($stable(ctrl_q) && $stable(adv_q)));

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  assert_ctrl_no_reset_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[15]);
endmodule

// File: tb/mii_mgmt_regs_tb.sv
`timescale 1ns/1ps
module mii_mgmt_regs_tb;
  localparam logic [7:0]  PA  = 8'd1;
  localparam logic [15:0] IDH = 16'h0243;
  localparam logic [15:0] IDL = 16'h0C54;

  logic clk = 1'b0, rst_n = 1'b0, link_up = 1'b0;
  logic tgt_we = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] tgt_wdata = '0;
  logic [15:0] wr_data = '0, rd_data;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] m_ctrl = 16'h3100, m_adv = 16'h01E1;
  bit m_link = 0;

  always #4 clk = ~clk;

  mii_mgmt_regs #(.PHY_ADDR(PA), .ID_HI(IDH), .ID_LO(IDL),
                  .TGT_W(32), .ADDR_SHIFT(8), .REG_SHIFT(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .tgt_we(tgt_we),
    .tgt_wdata(tgt_wdata), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data));

  function automatic logic [15:0] expv(int r);
    case (r)
      0: return m_ctrl;
      1: return m_link ? 16'h786C : 16'h7848;
      2: return IDH;
      3: return IDL;
      4: return m_adv;
      5: return m_link ? 16'h01E1 : 16'h0080;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_tgt(logic [7:0] a, logic [7:0] r);
    @(negedge clk); tgt_we = 1'b1; tgt_wdata = {16'h0, a, r};
    @(negedge clk); tgt_we = 1'b0;
  endtask

  task automatic do_read(logic [7:0] a, logic [7:0] r, output logic [15:0] v);
    set_tgt(a, r);
    rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic do_write(logic [7:0] a, logic [7:0] r, logic [15:0] d);
    set_tgt(a, r);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic sweep(string req);
    logic [15:0] v;
    for (int r = 0; r < 64; r++) begin
      do_read(PA, r[7:0], v);
      check(req, v, expv(r));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, held;
    repeat (3) @(negedge clk);
    check("R1 rd_data after reset", rd_data, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    do_read(PA, 8'd0, v); check("R1 control default", v, 16'h3100);
    do_read(PA, 8'd4, v); check("R1 advertisement default", v, 16'h01E1);

    // R2 R3 R10 R11 link down
    sweep("R2/R3/R10/R11 link down");
    // R4: link rises, read right after
    set_tgt(PA, 8'd1);
    link_up = 1'b1; m_link = 1;
    @(negedge clk);
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    check("R4 status after link rise", rd_data, 16'h786C);
    sweep("R2/R3/R10/R11 link up");
    set_tgt(PA, 8'd5);
    link_up = 1'b0; m_link = 0;
    @(negedge clk);
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    check("R4 partner after link fall", rd_data, 16'h0080);

    // R5 foreign address reads
    for (int a = 0; a < 256; a++) begin
      do_read(a[7:0], 8'd0, v);
      check("R5 address match", v, (a[7:0] == PA) ? m_ctrl : 16'hFFFF);
    end

    // R7 writes stored
    do_write(PA, 8'd0, 16'h1200); m_ctrl = 16'h1200;
    do_read(PA, 8'd0, v); check("R7 control stored", v, 16'h1200);
    do_write(PA, 8'd4, 16'hABCD); m_adv = 16'hABCD;
    do_read(PA, 8'd4, v); check("R7 advertisement stored", v, 16'hABCD);

    // R6 foreign writes ignored
    do_write(8'd7, 8'd0, 16'h0055);
    do_write(8'd0, 8'd4, 16'h0011);
    do_read(PA, 8'd0, v); check("R6 control untouched", v, m_ctrl);
    do_read(PA, 8'd4, v); check("R6 advertisement untouched", v, m_adv);

    // R9 writes to non-writable numbers ignored
    for (int r = 1; r < 40; r++)
      if (r != 4) do_write(PA, r[7:0], 16'hFFFF);
    sweep("R9 readback after read-only writes");

    // R8 soft reset
    do_write(PA, 8'd0, 16'h8000); m_ctrl = 16'h3100; m_adv = 16'h01E1;
    do_read(PA, 8'd0, v); check("R8 control restored", v, 16'h3100);
    do_read(PA, 8'd4, v); check("R8 advertisement restored", v, 16'h01E1);
    link_up = 1'b1; m_link = 1;
    do_write(PA, 8'd0, 16'hFFFF);
    sweep("R8 defaults with link up");

    // R12 hold without rd_en
    do_read(PA, 8'd1, held);
    set_tgt(PA, 8'd2);
    do_write(PA, 8'd4, 16'h0123); m_adv = 16'h0123;
    repeat (3) @(negedge clk);
    check("R12 rd_data held", rd_data, held);
    do_read(PA, 8'd4, v); check("R12 updates on strobe", v, 16'h0123);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule